// File: doc/BRIEF.md
# Latched Interval Timer with Interrupt

This block is a 16-bit down-counting interval timer on a byte-wide register bus. The host loads the live counter one byte at a time. It also loads a separate 16-bit reload latch one byte at a time. A one-cycle `tick` strobe paces the count, so the timer can run from a slower timer clock while the bus stays on the fast clock. A control register picks one of two modes. In continuous mode the timer re-arms from the latch each time it expires. In one-shot mode it raises a single expiry after each counter load.

Each expiry sets the timer bit in an interrupt flag register. A second flag bit is set by an external shift-completion strobe. An enable register masks both flags onto one level interrupt output. The host clears flags by writing ones to the flag register.

Top module: `latched_interval_timer`

## Requirements
- R1: After reset the counter reads 0xFFFF, both latch bytes read 0x00 (latch value 0 means a period of 65536 ticks), the control register reads 0x00, the flag register reads 0x00, the enable register reads 0x44 and `irq` is low.
- R2: A write to offset 4 replaces the counter low byte, keeps the high byte, and takes effect in the next cycle. Reads of offset 4 return the live counter low byte.
- R3: A write to offset 5 replaces the counter high byte, keeps the low byte, and takes effect in the next cycle. Reads of offset 5 return the live counter high byte.
- R4: Writes to offset 6 (low) and offset 7 (high) change only the latch, which reads back at the same offsets. They never alter the running counter.
- R5: After the counter is loaded with C, the first expiry happens on the (C+1)-th tick.
- R6: After that, while in continuous mode, expiries repeat every L ticks, where L is the latch value and L=0 stands for 65536.
- R7: Control register offset 11 bit 6 set selects continuous mode, and clear selects one-shot mode. In one-shot mode only the first expiry after a counter load sets the flag. Clearing bit 6 while in continuous mode cancels any pending expiry.
- R8: An expiry sets flag bit 6 of offset 13, and a `shift_evt` pulse sets flag bit 2. Both take effect in the next cycle.
- R9: Writing 1 to flag bit 6 or bit 2 clears that bit, and writing 0 leaves it unchanged. A set arriving in the same cycle as a clear wins.
- R10: `irq` is high exactly when a flag bit and its enable bit (offset 14, bits 6 and 2) are both set. Flag register bit 7 reads as `irq`.
- R11: Without `tick` the counter holds its value. A counter byte write in the same cycle as a tick loads the written value, and that tick neither counts nor expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count enable |
| shift_evt | input | 1 | Pulse that sets the shift flag |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hard coincidences are a timer expiry landing in the same cycle as a host write. One case is a write-one-to-clear of the timer flag. The bench parks the counter at zero and issues the tick and the clear together, then expects the flag still set (R9). The other case is a counter byte write that meets a tick. The bench issues both together and expects the written value unchanged, with no expiry (R11). A behavioural model updated on every edge judges both cases, and so does every other cycle of the run.

// File: rtl/latched_interval_timer.sv
module latched_interval_timer #(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int T1_BIT   = 6,
  parameter int SR_BIT   = 2,
  parameter int CONT_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          shift_evt,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int CW = 2 * DW;
  localparam logic [AW-1:0] A_CLO = AW'(4);
  localparam logic [AW-1:0] A_CHI = AW'(5);
  localparam logic [AW-1:0] A_LLO = AW'(6);
  localparam logic [AW-1:0] A_LHI = AW'(7);
  localparam logic [AW-1:0] A_CTL = AW'(11);
  localparam logic [AW-1:0] A_FLG = AW'(13);
  localparam logic [AW-1:0] A_ENA = AW'(14);
  localparam logic [DW-1:0] FMASK = DW'((1 << T1_BIT) | (1 << SR_BIT));

  logic [CW-1:0] cnt_q, latch_q;
  logic [DW-1:0] ctl_q, flg_q, ena_q;
  logic          armed_q;

  wire wr_clo = bus_wr && bus_addr == A_CLO;
  wire wr_chi = bus_wr && bus_addr == A_CHI;
  wire wr_llo = bus_wr && bus_addr == A_LLO;
  wire wr_lhi = bus_wr && bus_addr == A_LHI;
  wire wr_ctl = bus_wr && bus_addr == A_CTL;
  wire wr_flg = bus_wr && bus_addr == A_FLG;
  wire wr_ena = bus_wr && bus_addr == A_ENA;
  wire load    = wr_clo || wr_chi;
  wire cont    = ctl_q[CONT_BIT];
  wire at_zero = cnt_q == '0;
  wire expire  = tick && !load && at_zero && (cont || armed_q);

  wire [DW-1:0] set_v = (DW'(expire) << T1_BIT) | (DW'(shift_evt) << SR_BIT);
  wire [DW-1:0] clr_v = wr_flg ? (bus_wdata & FMASK) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      latch_q <= '0;
      ctl_q   <= '0;
      flg_q   <= '0;
      ena_q   <= FMASK;
      armed_q <= 1'b1;
    end else begin
      if (wr_clo)      cnt_q <= {cnt_q[CW-1:DW], bus_wdata};
      else if (wr_chi) cnt_q <= {bus_wdata, cnt_q[DW-1:0]};
      else if (tick)   cnt_q <= at_zero ? latch_q - 1'b1 : cnt_q - 1'b1;

      if (wr_llo) latch_q[DW-1:0]  <= bus_wdata;
      if (wr_lhi) latch_q[CW-1:DW] <= bus_wdata;

      if (wr_ctl) ctl_q <= bus_wdata;
      if (wr_ena) ena_q <= bus_wdata & FMASK;

      if (load)                                 armed_q <= 1'b1;
      else if (expire)                          armed_q <= 1'b0;
      else if (wr_ctl && cont && !bus_wdata[CONT_BIT]) armed_q <= 1'b0;

      flg_q <= (flg_q & ~clr_v) | set_v;
    end
  end

  assign irq = |(flg_q & ena_q);

  always_comb begin
    case (bus_addr)
      A_CLO:   bus_rdata = cnt_q[DW-1:0];
      A_CHI:   bus_rdata = cnt_q[CW-1:DW];
      A_LLO:   bus_rdata = latch_q[DW-1:0];
      A_LHI:   bus_rdata = latch_q[CW-1:DW];
      A_CTL:   bus_rdata = ctl_q;
      A_FLG:   bus_rdata = {irq, flg_q[DW-2:0]};
      A_ENA:   bus_rdata = ena_q;
      default: bus_rdata = '0;
    endcase
  end

  assert_load_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clo |=> cnt_q[DW-1:0] == $past(bus_wdata) && cnt_q[CW-1:DW] == $past(cnt_q[CW-1:DW]));

  assert_load_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_chi |=> cnt_q[CW-1:DW] == $past(bus_wdata) && cnt_q[DW-1:0] == $past(cnt_q[DW-1:0]));

  assert_latch_keeps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_llo || wr_lhi) && !tick) |=> $stable(cnt_q));

  assert_expiry_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && at_zero && cont) |=> flg_q[T1_BIT]);

  assert_clear_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flg && bus_wdata[SR_BIT] && !shift_evt) |=> !flg_q[SR_BIT]);

  assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));

  assert_reload_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && at_zero) |=> cnt_q == $past(latch_q) - 1'b1);
endmodule

// File: tb/latched_interval_timer_tb.sv
module latched_interval_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, shift_evt = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  latched_interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .shift_evt(shift_evt),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  int m_cnt, m_latch, m_ctl, m_flg, m_ena;
  bit m_armed;

  function automatic int m_irq();
    return ((m_flg & m_ena) != 0) ? 1 : 0;
  endfunction

  function automatic int m_read(int a);
    case (a)
      4: return m_cnt % 256;
      5: return m_cnt / 256;
      6: return m_latch % 256;
      7: return m_latch / 256;
      11: return m_ctl;
      13: return m_flg + 128 * m_irq();
      14: return m_ena;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      4: return "R2";
      5: return "R3";
      6, 7: return "R4";
      11: return "R7";
      13: return "R8";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 65535; m_latch = 0; m_ctl = 0; m_flg = 0; m_ena = 'h44; m_armed = 1;
    end else begin
      int a, w, nclr;
      bit ld, exp_now;
      a = bus_addr; w = bus_wdata;
      ld = bus_wr && (a == 4 || a == 5);
      exp_now = tick && !ld && m_cnt == 0 && (m_ctl[6] || m_armed);
      nclr = (bus_wr && a == 13) ? (w & 'h44) : 0;
      if (bus_wr && a == 11 && m_ctl[6] && !w[6]) m_armed = 0;
      if (ld) m_armed = 1;
      else if (exp_now) m_armed = 0;
      if (bus_wr && a == 4) m_cnt = (m_cnt / 256) * 256 + w;
      else if (bus_wr && a == 5) m_cnt = w * 256 + m_cnt % 256;
      else if (tick) m_cnt = (m_cnt == 0) ? (m_latch + 65535) % 65536 : m_cnt - 1;
      if (bus_wr && a == 6) m_latch = (m_latch / 256) * 256 + w;
      if (bus_wr && a == 7) m_latch = w * 256 + m_latch % 256;
      if (bus_wr && a == 11) m_ctl = w;
      if (bus_wr && a == 14) m_ena = w & 'h44;
      m_flg = m_flg & ~nclr;
      if (exp_now) m_flg = m_flg | 'h40;
      if (shift_evt) m_flg = m_flg | 'h04;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
      chk("R10", irq, m_irq());
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); bus_wr = 1; bus_addr = 4'(a); bus_wdata = 8'(d);
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(string tag, int a, int exp);
    @(negedge clk); bus_addr = 4'(a); #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); tick = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd("R1", 4, 'hFF); rd("R1", 5, 'hFF); rd("R1", 6, 0); rd("R1", 7, 0);
    rd("R1", 11, 0); rd("R1", 13, 0); rd("R1", 14, 'h44); chk("R1", irq, 0);

    wr(4, 5);  rd("R2", 4, 5); rd("R2", 5, 'hFF);
    wr(5, 0);  rd("R3", 5, 0); rd("R3", 4, 5);
    wr(6, 3);  wr(7, 0); rd("R4", 4, 5); rd("R4", 6, 3);
    idle(4);   rd("R11", 4, 5);

    wr(11, 'h40);
    ticks(5);  rd("R5", 13, 0); rd("R5", 4, 0);
    ticks(1);  rd("R5", 13, 'hC0); chk("R10", irq, 1);
    wr(13, 'h40); rd("R9", 13, 0);
    ticks(2);  rd("R6", 13, 0);
    ticks(1);  rd("R6", 13, 'hC0);
    wr(13, 'h40);

    wr(14, 0); @(negedge clk); shift_evt = 1; @(negedge clk); shift_evt = 0;
    rd("R8", 13, 'h04); chk("R10", irq, 0);
    wr(14, 'h04); rd("R10", 13, 'h84);
    wr(13, 'h04); rd("R9", 13, 0);

    wr(4, 0); wr(5, 0);
    @(negedge clk); tick = 1; bus_wr = 1; bus_addr = 13; bus_wdata = 'h40;
    @(negedge clk); tick = 0; bus_wr = 0;
    rd("R9", 13, 'h40);
    wr(13, 'h40);

    @(negedge clk); tick = 1; bus_wr = 1; bus_addr = 4; bus_wdata = 9;
    @(negedge clk); tick = 0; bus_wr = 0;
    rd("R11", 4, 9); rd("R11", 13, 0);

    wr(11, 0); wr(4, 2);
    ticks(3); rd("R7", 13, 'h40); wr(13, 'h40);
    ticks(9); rd("R7", 13, 0);
    wr(11, 'h40); wr(4, 4); ticks(2); wr(11, 0);
    ticks(10); rd("R7", 13, 0);

    wr(6, 0); wr(7, 0); wr(4, 0); wr(11, 'h40);
    ticks(1); rd("R6", 13, 'h40); wr(13, 'h40);
    ticks(65535); rd("R6", 13, 0);
    ticks(1); rd("R6", 13, 'h40);

    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule